// File: doc/BRIEF.md
# Spin Lock Unit with Exponential Backoff

This block places a single-bit lock word on a small shared bus. Several requesters, each with its own acquire engine, compete for it. To acquire, an engine runs an atomic test-and-set. It reads the word in one bus cycle and writes 1 in the next. A bus lock line is raised so that no other master can get in between the two cycles.

If the value read back was 1, the engine waits and then tries again. The wait doubles after every failure, up to a set ceiling, so a losing requester loads the bus less and less often. A release is a single bus write of 0.

The bus has a fixed-priority arbiter, and the lowest requester index wins. Once a master is granted a locked read phase, the arbiter keeps the grant on that master for the following set phase.

Top module: `splk_top`

## Requirements
- R1: After reset the lock word reads 0, and every granted, rel_err and bus_gnt bit is 0.
- R2: An acquire request sampled at a clock edge while the engine is idle leads to a read bus cycle after that edge, then a set-to-1 bus cycle. bus_lock_line is 1 during both. If the value read was 0, granted for that requester goes to 1 after the third edge, counting the sampling edge.
- R3: At most one bus_gnt bit is 1 in any cycle. When no locked sequence is open, the lowest-index requesting master is granted.
- R4: In the cycle after a granted locked read phase, the bus grant stays on the same master, even when a lower-index master is requesting.
- R5: After a failed attempt (read value 1), the engine waits D cycles before its next read, where D starts at 1 and doubles after each failure. The number of cycles between successive rises of that requester's bus_gnt bit is 2 + D, giving 3, 4, 6, ...
- R6: The wait D saturates at 2^BO_MAX_LOG, which is 8 with the default parameters. Further failures keep the gap at 10 cycles.
- R7: After a successful acquire, the wait D returns to 1. The first gap of the next contended acquire is 3 cycles.
- R8: granted stays 1 until the holder's release write is performed. A release request sampled at an edge causes a bus write of 0. granted and lock_val are both 0 after the second edge.
- R9: A release request from a requester that does not hold the lock leaves lock_val and all granted bits unchanged. It produces a one-cycle pulse on that requester's rel_err bit, visible after the sampling edge.
- R10: An acquire request from the current holder has no effect. granted stays 1, lock_val stays 1, and no bus cycle is issued.
- R11: At most one granted bit is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | N_REQ | Per-requester acquire request, sampled at each edge |
| rel_req | input | N_REQ | Per-requester release request, sampled at each edge |
| granted | output | N_REQ | Requester holds the lock |
| rel_err | output | N_REQ | One-cycle pulse: release from a non-holder |
| bus_gnt | output | N_REQ | Shared-bus grant, one-hot or zero |
| bus_lock_line | output | 1 | Granted master is inside a locked test-and-set |
| lock_val | output | 1 | Current lock word value |

## Verification
Every result arrives a fixed number of edges after its stimulus. These counts are:
- granted: three edges after an acquire that succeeds.
- granted and lock_val: two edges after a release, when both drop.
- rel_err: one edge after an invalid release.
- bus_gnt: in the same cycle as the engine state that requests.

The bench drives inputs on falling edges and samples them one falling edge per passed rising edge, so each table entry carries its own edge count. The backoff checks count cycles between rises of one bus_gnt bit and compare those gaps with 2 + D, which tests the doubling and the ceiling without looking at internal counters.

// File: rtl/splk_pkg.sv
package splk_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_TAS_RD = 2'd1,
        OP_TAS_SET = 2'd2,
        OP_CLEAR = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_SET  = 3'd2,
        ST_WAIT = 3'd3,
        ST_HOLD = 3'd4,
        ST_REL  = 3'd5
    } eng_state_e;

    function automatic logic is_holder(eng_state_e s);
        return (s == ST_HOLD) || (s == ST_REL);
    endfunction

    function automatic bus_op_e op_of(eng_state_e s);
        case (s)
            ST_RD:   return OP_TAS_RD;
            ST_SET:  return OP_TAS_SET;
            ST_REL:  return OP_CLEAR;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/splk_word.sv
module splk_word
    import splk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid_i,
    input  bus_op_e op_i,
    output logic    val_o
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (valid_i) begin
            if (op_i == OP_TAS_SET)
                lock_q <= 1'b1;
            else if (op_i == OP_CLEAR)
                lock_q <= 1'b0;
        end
    end

    assign val_o = lock_q;

    // R8: a performed clear leaves the word at 0
    a_r8_clear_word: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_CLEAR) |=> !val_o);

    // R2: a performed set phase leaves the word at 1
    a_r2_set_word: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_TAS_SET) |=> val_o);

endmodule

// File: rtl/splk_arbiter.sv
module splk_arbiter #(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] lock_i,
    input  logic [N_REQ-1:0] rd_phase_i,
    output logic [N_REQ-1:0] gnt_o
);
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic             hold_q;
    logic [IDX_W-1:0] hold_idx_q;
    logic             hold_d;
    logic [IDX_W-1:0] gnt_idx;
    logic             found;

    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        if (hold_q) begin
            gnt_o[hold_idx_q] = req_i[hold_idx_q];
        end else begin
            for (int i = 0; i < N_REQ; i++) begin
                if (req_i[i] && !found) begin
                    gnt_o[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N_REQ; i++)
            if (gnt_o[i]) gnt_idx = IDX_W'(i);
    end

    assign hold_d = |(gnt_o & lock_i & rd_phase_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            hold_q     <= hold_d;
            hold_idx_q <= gnt_idx;
        end
    end

    // R3: one master at most on the bus
    a_r3_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    // R3: a request never goes unserved when the bus is free
    a_r3_no_idle_bus: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && |req_i) |-> |gnt_o);

endmodule

// File: rtl/splk_engine.sv
module splk_engine
    import splk_pkg::*;
#(
    parameter int BO_MAX_LOG = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    acq_i,
    input  logic    rel_i,
    input  logic    bus_gnt_i,
    input  logic    rd_val_i,
    output logic    bus_req_o,
    output logic    bus_lock_o,
    output logic    rd_phase_o,
    output bus_op_e bus_op_o,
    output logic    granted_o,
    output logic    rel_err_o
);
    localparam int DLY_W = BO_MAX_LOG + 1;
    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);
    localparam logic [DLY_W-1:0] DLY_MAX = DLY_ONE << BO_MAX_LOG;

    eng_state_e       state_q;
    logic             fail_q;
    logic [DLY_W-1:0] delay_q;
    logic [DLY_W-1:0] cnt_q;
    logic             err_q;
    logic [DLY_W-1:0] delay_nxt;

    assign delay_nxt = (delay_q == DLY_MAX) ? DLY_MAX : (delay_q << 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b0;
            delay_q <= DLY_ONE;
            cnt_q   <= DLY_ONE;
            err_q   <= 1'b0;
        end else begin
            err_q <= rel_i && !is_holder(state_q);
            case (state_q)
                ST_IDLE: if (acq_i) state_q <= ST_RD;
                ST_RD: if (bus_gnt_i) begin
                    fail_q  <= rd_val_i;
                    state_q <= ST_SET;
                end
                ST_SET: if (bus_gnt_i) begin
                    if (fail_q) begin
                        cnt_q   <= delay_q;
                        delay_q <= delay_nxt;
                        state_q <= ST_WAIT;
                    end else begin
                        delay_q <= DLY_ONE;
                        state_q <= ST_HOLD;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == DLY_ONE) state_q <= ST_RD;
                    else                  cnt_q   <= cnt_q - DLY_ONE;
                end
                ST_HOLD: if (rel_i) state_q <= ST_REL;
                ST_REL:  if (bus_gnt_i) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_op_o   = op_of(state_q);
    assign bus_req_o  = (bus_op_o != OP_NONE);
    assign bus_lock_o = (state_q == ST_RD) || (state_q == ST_SET);
    assign rd_phase_o = (state_q == ST_RD);
    assign granted_o  = is_holder(state_q);
    assign rel_err_o  = err_q;

    // R6: the wait never exceeds its ceiling
    a_r6_delay_cap: assert property (@(posedge clk) disable iff (rst)
        delay_q <= DLY_MAX);

    // R5: the wait is always a power of two
    a_r5_delay_pow2: assert property (@(posedge clk) disable iff (rst)
        $onehot(delay_q));

    // R2: ownership begins only out of a set phase
    a_r2_grant_after_set: assert property (@(posedge clk) disable iff (rst)
        $rose(granted_o) |-> $past(state_q == ST_SET));

    // R8: ownership ends once the clear write is performed
    a_r8_release_drops: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REL && bus_gnt_i) |=> !granted_o);

    // R7: a successful acquire restarts the wait at one
    a_r7_delay_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(granted_o) |-> (delay_q == DLY_ONE));

endmodule

// File: rtl/splk_top.sv
module splk_top
    import splk_pkg::*;
#(
    parameter int N_REQ      = 4,
    parameter int BO_MAX_LOG = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] acq_req,
    input  logic [N_REQ-1:0] rel_req,
    output logic [N_REQ-1:0] granted,
    output logic [N_REQ-1:0] rel_err,
    output logic [N_REQ-1:0] bus_gnt,
    output logic             bus_lock_line,
    output logic             lock_val
);
    logic [N_REQ-1:0] eng_req;
    logic [N_REQ-1:0] eng_lock;
    logic [N_REQ-1:0] eng_rd;
    bus_op_e          eng_op [N_REQ];
    bus_op_e          sel_op;

    for (genvar g = 0; g < N_REQ; g++) begin : g_eng
        splk_engine #(.BO_MAX_LOG(BO_MAX_LOG)) u_eng (
            .clk        (clk),
            .rst        (rst),
            .acq_i      (acq_req[g]),
            .rel_i      (rel_req[g]),
            .bus_gnt_i  (bus_gnt[g]),
            .rd_val_i   (lock_val),
            .bus_req_o  (eng_req[g]),
            .bus_lock_o (eng_lock[g]),
            .rd_phase_o (eng_rd[g]),
            .bus_op_o   (eng_op[g]),
            .granted_o  (granted[g]),
            .rel_err_o  (rel_err[g])
        );
    end

    splk_arbiter #(.N_REQ(N_REQ)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req_i      (eng_req),
        .lock_i     (eng_lock),
        .rd_phase_i (eng_rd),
        .gnt_o      (bus_gnt)
    );

    always_comb begin
        sel_op = OP_NONE;
        for (int i = 0; i < N_REQ; i++)
            if (bus_gnt[i]) sel_op = eng_op[i];
    end

    assign bus_lock_line = |(bus_gnt & eng_lock);

    splk_word u_word (
        .clk     (clk),
        .rst     (rst),
        .valid_i (|bus_gnt),
        .op_i    (sel_op),
        .val_o   (lock_val)
    );

    // R11: mutual exclusion among requesters
    a_r11_mutex: assert property (@(posedge clk) disable iff (rst)
        $countones(granted) <= 1);

    // R4: a locked read phase keeps the bus for the next cycle
    a_r4_hold_bus: assert property (@(posedge clk) disable iff (rst)
        (bus_lock_line && sel_op == OP_TAS_RD) |=> $stable(bus_gnt));

    // R11: a holder always sees the word set
    a_r11_holder_word: assert property (@(posedge clk) disable iff (rst)
        (|granted) |-> lock_val);

endmodule

// File: tb/splk_top_tb.sv
module splk_top_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] acq_req, rel_req, granted, rel_err, bus_gnt;
    logic         bus_lock_line, lock_val;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    splk_top #(.N_REQ(N), .BO_MAX_LOG(3)) u_dut (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
        .granted(granted), .rel_err(rel_err), .bus_gnt(bus_gnt),
        .bus_lock_line(bus_lock_line), .lock_val(lock_val)
    );

    typedef struct packed {
        logic [3:0] acq;
        logic [3:0] rel;
        logic [3:0] w;
        logic [3:0] gr;
        logic       lk;
        logic [3:0] err;
    } step_t;

    localparam int NSTEP = 9;
    localparam step_t TBL [NSTEP] = '{
        '{4'b0001, 4'b0000, 4'd3, 4'b0001, 1'b1, 4'b0000}, // R2 acquire
        '{4'b0000, 4'b0010, 4'd1, 4'b0001, 1'b1, 4'b0010}, // R9 bad release
        '{4'b0000, 4'b0001, 4'd2, 4'b0000, 1'b0, 4'b0000}, // R8 release
        '{4'b0100, 4'b0000, 4'd3, 4'b0100, 1'b1, 4'b0000}, // R2 acquire
        '{4'b0100, 4'b0000, 4'd3, 4'b0100, 1'b1, 4'b0000}, // R10 re-acquire
        '{4'b0000, 4'b0100, 4'd2, 4'b0000, 1'b0, 4'b0000}, // R8 release
        '{4'b0000, 4'b1000, 4'd1, 4'b0000, 1'b0, 4'b1000}, // R9 bad release
        '{4'b1000, 4'b0000, 4'd3, 4'b1000, 1'b1, 4'b0000}, // R2 acquire
        '{4'b0000, 4'b1000, 4'd2, 4'b0000, 1'b0, 4'b0000}  // R8 release
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic pulse(input logic [3:0] a, input logic [3:0] r, input int w);
        @(negedge clk);
        acq_req = a;
        rel_req = r;
        @(negedge clk);
        acq_req = '0;
        rel_req = '0;
        for (int k = 1; k < w; k++) @(negedge clk);
    endtask

    task automatic wait_granted(input int idx, input string tag);
        int t = 0;
        while (!granted[idx] && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk(tag, {31'd0, granted[idx]}, 32'd1);
    endtask

    // records the cycle numbers of the first cnt rises of bus_gnt[idx]
    task automatic rises(input int idx, input int cnt, output int r [6]);
        int n = 0;
        int t = 0;
        logic prev = 1'b0;
        for (int k = 0; k < 6; k++) r[k] = 0;
        while (n < cnt && t < 400) begin
            if (bus_gnt[idx] && !prev) begin
                r[n] = t;
                n++;
            end
            prev = bus_gnt[idx];
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d cycles expected=fewer", cyc);
        report();
    end

    initial begin
        int r [6];
        acq_req = '0;
        rel_req = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 lock_val", {31'd0, lock_val}, 32'd0);
        chk("R1 granted", {28'd0, granted}, 32'd0);
        chk("R1 bus_gnt", {28'd0, bus_gnt}, 32'd0);
        chk("R1 rel_err", {28'd0, rel_err}, 32'd0);

        // table walk: single requester sequences
        for (int s = 0; s < NSTEP; s++) begin
            pulse(TBL[s].acq, TBL[s].rel, int'(TBL[s].w));
            chk($sformatf("R2/R8/R9/R10 step%0d granted", s), {28'd0, granted}, {28'd0, TBL[s].gr});
            chk($sformatf("R2/R8/R9/R10 step%0d lock_val", s), {31'd0, lock_val}, {31'd0, TBL[s].lk});
            chk($sformatf("R9 step%0d rel_err", s), {28'd0, rel_err}, {28'd0, TBL[s].err});
        end

        // R10: a holder's repeated acquire issues no bus cycle
        pulse(4'b0001, 4'b0000, 3);
        @(negedge clk);
        acq_req = 4'b0001;
        @(negedge clk);
        acq_req = '0;
        chk("R10 no bus cycle", {28'd0, bus_gnt}, 32'd0);
        @(negedge clk);
        chk("R10 no bus cycle later", {28'd0, bus_gnt}, 32'd0);
        pulse(4'b0000, 4'b0001, 2);

        // R2 and R3: bus cycles of one acquire, lowest index among all
        @(negedge clk);
        acq_req = 4'b0010;
        @(negedge clk);
        acq_req = '0;
        chk("R2 read phase grant", {28'd0, bus_gnt}, 32'b0010);
        chk("R2 read phase lock line", {31'd0, bus_lock_line}, 32'd1);
        @(negedge clk);
        chk("R2 set phase lock line", {31'd0, bus_lock_line}, 32'd1);
        chk("R2 not yet granted", {28'd0, granted}, 32'd0);
        @(negedge clk);
        chk("R2 granted after set", {28'd0, granted}, 32'b0010);
        chk("R2 lock line dropped", {31'd0, bus_lock_line}, 32'd0);
        pulse(4'b0000, 4'b0010, 2);

        // R3: simultaneous acquires, lowest index granted first
        @(negedge clk);
        acq_req = 4'b0110;
        @(negedge clk);
        acq_req = '0;
        chk("R3 priority grant", {28'd0, bus_gnt}, 32'b0010);
        wait_granted(1, "R3 low index wins");
        pulse(4'b0000, 4'b0010, 2);
        wait_granted(2, "R3 second gets lock later");
        pulse(4'b0000, 4'b0100, 2);
        chk("R8 word clear", {31'd0, lock_val}, 32'd0);

        // R4: lower index arrives during a locked sequence of index 3
        @(negedge clk);
        acq_req = 4'b1000;
        @(negedge clk);
        acq_req = 4'b0001;
        @(negedge clk);
        acq_req = '0;
        chk("R4 hold grant", {28'd0, bus_gnt}, 32'b1000);
        chk("R4 lock line", {31'd0, bus_lock_line}, 32'd1);
        @(negedge clk);
        chk("R4 next master after sequence", {28'd0, bus_gnt}, 32'b0001);
        chk("R4 word set by holder", {31'd0, lock_val}, 32'd1);
        pulse(4'b0000, 4'b1000, 1);
        wait_granted(0, "R4 waiting master later acquires");
        pulse(4'b0000, 4'b0001, 2);

        // R5/R6: requester 1 retries against holder 0
        pulse(4'b0001, 4'b0000, 3);
        @(negedge clk);
        acq_req = 4'b0010;
        @(negedge clk);
        acq_req = '0;
        rises(1, 6, r);
        chk("R5 gap d=1", r[1] - r[0], 32'd3);
        chk("R5 gap d=2", r[2] - r[1], 32'd4);
        chk("R5 gap d=4", r[3] - r[2], 32'd6);
        chk("R6 gap d=8", r[4] - r[3], 32'd10);
        chk("R6 gap saturated", r[5] - r[4], 32'd10);
        pulse(4'b0000, 4'b0001, 1);
        wait_granted(1, "R5 retry eventually acquires");
        chk("R11 single holder", {28'd0, granted}, 32'b0010);

        // R7: after success, the next contended acquire starts at d=1
        pulse(4'b0000, 4'b0010, 2);
        pulse(4'b0001, 4'b0000, 3);
        @(negedge clk);
        acq_req = 4'b0010;
        @(negedge clk);
        acq_req = '0;
        rises(1, 2, r);
        chk("R7 delay reset gap", r[1] - r[0], 32'd3);
        pulse(4'b0000, 4'b0001, 1);
        wait_granted(1, "R7 acquire after reset of delay");
        chk("R11 mutex", {28'd0, granted}, 32'b0010);
        pulse(4'b0000, 4'b0010, 2);
        chk("R8 final clear", {31'd0, lock_val}, 32'd0);

        report();
    end
endmodule